// File: doc/BRIEF.md
# Reloading Interval Pulse Generator

A free-running counter paces a periodic event. Software writes a start value into a load register and sets control bits. Those bits choose the count direction, start or stop counting, enable the output, select the output polarity and choose between repeating and one-shot operation. Each time the counter reaches its terminal value (zero when counting down, all ones when counting up), the block does three things. It raises an interrupt flag, drives the generate output to its active level for one clock, and reloads the counter from the load register after one extra clock.

Because of the extra reload cycle, a load value L gives pulses every L+2 clocks when counting down, and every MAX−L+2 clocks when counting up. MAX is the all-ones value of the counter width. A separate strobe copies the load register into the counter at any time, which restarts the current interval. Register access is modelled as plain write strobes and read ports.

Top module: `interval_pulse_gen`

## Requirements
- R1: After reset, the load register, control register, counter and interrupt flag read zero, and the generate output is low.
- R2: When counting down (ctrl bit 1 = 0) with run set (ctrl bit 0 = 1), terminal count is zero. Generate pulses last exactly one clock and repeat every L+2 clocks. The first pulse comes L+1 clocks after the edge at which counting starts from L.
- R3: When counting up (ctrl bit 1 = 1), terminal count is all ones and pulses repeat every MAX−L+2 clocks, with the first pulse MAX−L+1 clocks after counting starts.
- R4: With ctrl bit 3 = 0 the output is active-high. With ctrl bit 3 = 1 it is active-low: it idles high and pulses low.
- R5: While ctrl bit 2 (output enable) is 0, the generate output stays at its inactive level even though terminal counts still occur.
- R6: While run (ctrl bit 0) is 0, the counter holds its value.
- R7: A pulse on load_now copies the load register into the counter at the next edge. This overrides counting and cancels a pending reload.
- R8: The interrupt flag sets at every terminal count and is cleared by irq_clr. If both happen on the same edge, the flag is set.
- R9: With ctrl bit 4 (auto-reload) = 0, the terminal count clears the run bit and the counter stays at the terminal value, so only one pulse is produced.
- R10: load_wr and ctrl_wr update load_rdata and ctrl_rdata at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_wr | input | 1 | Write strobe for the load register |
| load_wdata | input | WIDTH | Load register write data |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 5 | Control bits: 0 run, 1 up, 2 output enable, 3 active-low, 4 auto-reload |
| irq_clr | input | 1 | Clears the interrupt flag |
| load_now | input | 1 | Copies the load register into the counter |
| load_rdata | output | WIDTH | Load register value |
| ctrl_rdata | output | 5 | Control register value |
| count_rdata | output | WIDTH | Current counter value |
| irq | output | 1 | Interrupt flag |
| gen_out | output | 1 | Generate output |

## Verification
Two things can land on the same edge: software clearing the interrupt flag, and a terminal count setting it. The bench computes the edge of a terminal count from the load value and holds irq_clr high across exactly that edge. It then expects the flag to read 1, and expects a later clear with no terminal count to bring it to 0. A scoreboard predicts the clock number of every generate pulse and compares it against the pulses the output actually shows.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    localparam int CTRL_W = 5;

    // bit order matches the ctrl_wdata layout: run is bit 0
    typedef struct packed {
        logic autorl;
        logic act_low;
        logic gen_en;
        logic up;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/ipg_regs.sv
module ipg_regs
    import ipg_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr,
    input  logic [WIDTH-1:0] load_wdata,
    input  logic             ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic             irq_clr,
    input  logic             tc_evt,
    output logic [WIDTH-1:0] load_q,
    output ctrl_t            ctrl_q,
    output logic             irq_q
);

    typedef struct packed {
        logic [WIDTH-1:0] load;
        ctrl_t            ctrl;
        logic             irq;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_wr) begin
            st_d.load = load_wdata;
        end
        if (ctrl_wr) begin
            st_d.ctrl = ctrl_t'(ctrl_wdata);
        end else if (tc_evt && !st_q.ctrl.autorl) begin
            st_d.ctrl.run = 1'b0;
        end
        if (irq_clr) begin
            st_d.irq = 1'b0;
        end
        if (tc_evt) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_q = st_q.load;
    assign ctrl_q = st_q.ctrl;
    assign irq_q  = st_q.irq;

endmodule

// File: rtl/ipg_core.sv
module ipg_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             up,
    input  logic             autorl,
    input  logic             load_now,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] cnt,
    output logic             pend,
    output logic             pulse,
    output logic             tc_evt
);

    localparam logic [WIDTH-1:0] TOP_V = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOT_V = '0;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             pend;
        logic             pulse;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     at_term;

    always_comb begin
        at_term = (st_q.cnt == (up ? TOP_V : BOT_V));
        tc_evt  = run && !st_q.pend && !load_now && at_term;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (load_now) begin
            st_d.cnt  = load_val;
            st_d.pend = 1'b0;
        end else if (st_q.pend) begin
            // extra reload cycle: gives the interval its +2
            st_d.pend = 1'b0;
            if (autorl) begin
                st_d.cnt = load_val;
            end
        end else if (run) begin
            if (at_term) begin
                st_d.pend  = 1'b1;
                st_d.pulse = 1'b1;
            end else if (up) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign pend  = st_q.pend;
    assign pulse = st_q.pulse;

endmodule

// File: rtl/ipg_out.sv
module ipg_out (
    input  logic pulse,
    input  logic gen_en,
    input  logic act_low,
    output logic gen_out
);

    always_comb begin
        gen_out = (gen_en & pulse) ^ act_low;
    end

endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
    import ipg_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic [WIDTH-1:0]  load_wdata,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              irq_clr,
    input  logic              load_now,
    output logic [WIDTH-1:0]  load_rdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [WIDTH-1:0]  count_rdata,
    output logic              irq,
    output logic              gen_out
);

    ctrl_t            ctrl_w;
    logic [WIDTH-1:0] load_w;
    logic             tc_w;
    logic             pend_w;
    logic             pulse_w;

    ipg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wr    (load_wr),
        .load_wdata (load_wdata),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .irq_clr    (irq_clr),
        .tc_evt     (tc_w),
        .load_q     (load_w),
        .ctrl_q     (ctrl_w),
        .irq_q      (irq)
    );

    ipg_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_w.run),
        .up       (ctrl_w.up),
        .autorl   (ctrl_w.autorl),
        .load_now (load_now),
        .load_val (load_w),
        .cnt      (count_rdata),
        .pend     (pend_w),
        .pulse    (pulse_w),
        .tc_evt   (tc_w)
    );

    ipg_out u_out (
        .pulse   (pulse_w),
        .gen_en  (ctrl_w.gen_en),
        .act_low (ctrl_w.act_low),
        .gen_out (gen_out)
    );

    assign load_rdata = load_w;
    assign ctrl_rdata = ctrl_w;

endmodule

// File: rtl/ipg_chk.sv
module ipg_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             irq_clr,
    input logic             load_now,
    input logic [WIDTH-1:0] load_rdata,
    input logic [4:0]       ctrl_rdata,
    input logic [WIDTH-1:0] count_rdata,
    input logic             irq,
    input logic             gen_out,
    input logic             pulse,
    input logic             pend
);

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R4
    pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && ctrl_rdata[2]) |-> (gen_out == !ctrl_rdata[3]));

    // R5
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[2] |-> (gen_out == ctrl_rdata[3]));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[0] && !load_now && !pend) |=> $stable(count_rdata));

    // R7
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (count_rdata == $past(load_rdata) && !pulse));

    // R8
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (irq == pulse));

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> irq);

    // R9
    oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !ctrl_rdata[4] && !$past(ctrl_wr)) |-> !ctrl_rdata[0]);

endmodule

bind interval_pulse_gen ipg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .irq_clr     (irq_clr),
    .load_now    (load_now),
    .load_rdata  (load_rdata),
    .ctrl_rdata  (ctrl_rdata),
    .count_rdata (count_rdata),
    .irq         (irq),
    .gen_out     (gen_out),
    .pulse       (pulse_w),
    .pend        (pend_w)
);

// File: tb/interval_pulse_gen_tb.sv
module interval_pulse_gen_tb;

    localparam int W = 32;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_wr = 1'b0;
    logic [W-1:0] load_wdata = '0;
    logic         ctrl_wr = 1'b0;
    logic [4:0]   ctrl_wdata = '0;
    logic         irq_clr = 1'b0;
    logic         load_now = 1'b0;
    logic [W-1:0] load_rdata;
    logic [4:0]   ctrl_rdata;
    logic [W-1:0] count_rdata;
    logic         irq;
    logic         gen_out;

    int     n_tests = 0;
    int     n_fail = 0;
    int     cyc = 0;
    int     wedge = 0;
    int     exp_q[$];
    logic   exp_act = 1'b1;
    logic   mon_on = 1'b0;
    string  sb_req = "R2";
    logic   done = 1'b0;

    always #5 clk = ~clk;

    interval_pulse_gen #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_wr     (load_wr),
        .load_wdata  (load_wdata),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (ctrl_wdata),
        .irq_clr     (irq_clr),
        .load_now    (load_now),
        .load_rdata  (load_rdata),
        .ctrl_rdata  (ctrl_rdata),
        .count_rdata (count_rdata),
        .irq         (irq),
        .gen_out     (gen_out)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: each active output cycle must match the next predicted edge
    always @(posedge clk) begin
        #2;
        if (rst_n && mon_on && gen_out === exp_act) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: actual pulse at %0d expected none", sb_req, cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_fail++;
                    $display("FAIL %s: actual pulse at %0d expected %0d", sb_req, cyc, e);
                end
            end
        end
    end

    task automatic push(input int base, input longint period, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(base + int'(period) - 1 + i * int'(period));
    endtask

    task automatic wr_load(input logic [W-1:0] v);
        load_wr = 1'b1; load_wdata = v;
        @(negedge clk);
        load_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        wedge = cyc + 1;
        if (v[2]) exp_act = ~v[3];
        else      exp_act = v[3] ? 1'b0 : 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic do_load_now();
        load_now = 1'b1;
        @(negedge clk);
        load_now = 1'b0;
    endtask

    task automatic do_irq_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [W-1:0] snap;
        int ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 load", load_rdata, 0);
        chk("R1 ctrl", ctrl_rdata, 0);
        chk("R1 count", count_rdata, 0);
        chk("R1 irq", irq, 0);
        chk("R1 gen_out", gen_out, 0);
        mon_on = 1'b1;

        // R10 / R7 / R6: load, copy, hold while stopped
        wr_load(32'd3);
        chk("R10 load readback", load_rdata, 3);
        do_load_now();
        chk("R7 copy", count_rdata, 3);
        repeat (3) @(negedge clk);
        chk("R6 hold stopped", count_rdata, 3);

        // R2 down counting, active high, auto-reload
        sb_req = "R2";
        wr_ctrl(5'b10101);
        chk("R10 ctrl readback", ctrl_rdata, 5'h15);
        push(wedge, 5, 3);
        repeat (15) @(negedge clk);
        wr_ctrl(5'b10100);
        snap = count_rdata;
        repeat (3) @(negedge clk);
        chk("R6 hold after stop", count_rdata, snap);
        chk("R2 pulses consumed", exp_q.size(), 0);
        chk("R8 irq set", irq, 1);
        do_irq_clr();
        chk("R8 irq cleared", irq, 0);

        // R3 / R4 up counting, active low
        sb_req = "R3";
        wr_load(MAXV - 32'd4);
        do_load_now();
        chk("R7 copy up", count_rdata, MAXV - 32'd4);
        wr_ctrl(5'b11111);
        push(wedge, longint'(MAXV) - longint'(MAXV - 32'd4) + 2, 3);
        repeat (18) @(negedge clk);
        wr_ctrl(5'b11110);
        @(negedge clk);
        chk("R3 pulses consumed", exp_q.size(), 0);
        chk("R4 idle high", gen_out, 1);
        do_irq_clr();

        // R5 output disabled, terminal counts still happen
        sb_req = "R5";
        do_load_now();
        wr_ctrl(5'b11011);
        ok = 1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (gen_out !== 1'b1) ok = 0;
        end
        chk("R5 output inactive", ok, 1);
        chk("R8 irq with output off", irq, 1);
        wr_ctrl(5'b11010);
        do_irq_clr();
        chk("R8 irq cleared again", irq, 0);

        // R8 clear and set on the same edge
        sb_req = "R8";
        wr_load(32'd2);
        do_load_now();
        wr_ctrl(5'b10101);
        push(wedge, 4, 1);
        repeat (2) @(negedge clk);
        do_irq_clr();
        chk("R8 set wins over clear", irq, 1);
        wr_ctrl(5'b10100);
        do_irq_clr();
        chk("R8 clear alone", irq, 0);

        // R9 one-shot
        sb_req = "R9";
        wr_load(32'd3);
        do_load_now();
        wr_ctrl(5'b00101);
        push(wedge, 5, 1);
        repeat (12) @(negedge clk);
        chk("R9 run cleared", ctrl_rdata[0], 0);
        chk("R9 count held", count_rdata, 0);
        chk("R9 single pulse", exp_q.size(), 0);
        do_irq_clr();

        // R7 restart mid-interval
        sb_req = "R7";
        wr_load(32'd10);
        do_load_now();
        wr_ctrl(5'b10101);
        repeat (4) @(negedge clk);
        chk("R2 decrement", count_rdata, 6);
        do_load_now();
        chk("R7 restart value", count_rdata, 10);
        push(wedge + 5, 12, 1);
        repeat (13) @(negedge clk);
        wr_ctrl(5'b10100);
        repeat (3) @(negedge clk);
        chk("R7 restart pulse seen", exp_q.size(), 0);

        finish_up();
    end

endmodule